// File: doc/BRIEF.md
# Indirect Wake-Up Source Configurator

This block holds the wake-up settings for sixteen sources behind one 32-bit register. A write at the register's offset does one of two things, depending on a command bit. It either stores a new setting for the source named in the index field, or it only aims the read pointer at that source. A read returns the settings of whichever source the pointer names. Every write moves the pointer to the index in its data.

Each source has three settings:
- a core-0 enable,
- an active polarity,
- a core-1 enable.

The sixteen live wake-up inputs pass through a two-flop synchroniser. A synchronised input is active when its level equals its polarity bit. The block raises a registered fast-restart request to core 0 when any core-0-enabled source is active. It raises a request to core 1 in the same way, using the core-1 enables.

Top module: `wakeup_cfg_reg`

## Requirements
- R1: After reset, every entry is cleared (both enables 0, polarity 0), the read pointer is 0, and both restart outputs are 0.
- R2: A write at the offset with data bit 24 set stores three fields into the entry named by data bits 3:0: bit 16 (core-0 enable), bit 17 (polarity) and bit 20 (core-1 enable). The write also sets the read pointer to that index.
- R3: A write at the offset with data bit 24 clear sets the read pointer to data bits 3:0 and leaves every stored entry unchanged.
- R4: A read at the offset raises `bus_rvalid` for exactly the cycle after the access. In that cycle `bus_rdata` holds the pointer in bits 3:0, and the pointed entry's core-0 enable, polarity and core-1 enable in bits 16, 17 and 20.
- R5: Bit 24 and every bit other than 3:0, 16, 17 and 20 read as zero, whatever was written to them.
- R6: An access at any other offset changes no entry and does not move the pointer. A read at any other offset produces no `bus_rvalid`.
- R7: `restart_core0` is the OR over all sources of (core-0 enable AND synchronised input equal to polarity). It is registered, so it follows an input change after three clock edges.
- R8: `restart_core1` is formed in the same way from the core-1 enables, independently of the core-0 enables.
- R9: With polarity 0, a source is active while its input is low. With polarity 1, a source is active while its input is high.
- R10: The sixteen entries are independent: writing one entry leaves the other fifteen unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| wake_in | input | 16 | Raw wake-up inputs, one per source |
| restart_core0 | output | 1 | Fast-restart request to core 0 |
| restart_core1 | output | 1 | Fast-restart request to core 1 |

## Verification
The embedded properties check the following on every cycle:
- pointer-only writes and accesses at other offsets leave the stored entries intact;
- a read answers on exactly the next cycle;
- the unused read bits stay zero;
- a restart request never appears unless some entry had its enable for that core set.

Some behaviours only the bench scenarios can show, because they need the stored values tracked over time:
- the exact read-back contents after sequences of stores and pointer moves;
- the three-edge input latency;
- active-low against active-high polarity;
- the independence of the two cores;
- the isolation between all sixteen entries.

// File: rtl/wakeup_cfg_reg.sv
module wakeup_cfg_reg #(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NUM_SRC-1:0] wake_in,
  output logic              restart_core0,
  output logic              restart_core1
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int CMD_B = 24;
  localparam int EN_B  = 16;
  localparam int POL_B = 17;
  localparam int EN1_B = 20;
  localparam logic [31:0] USED_MASK = (32'(1) << EN_B) | (32'(1) << POL_B) |
                                      (32'(1) << EN1_B) | ((32'(1) << IDX_W) - 32'(1));

  logic [NUM_SRC-1:0] en_q, pol_q, en1_q, sync1, sync2;
  logic [IDX_W-1:0]   ptr_q;
  logic [31:0]        rd_word;

  wire hit   = bus_valid && (bus_addr == REG_OFFSET);
  wire wr    = hit && bus_write;
  wire rd    = hit && !bus_write;
  wire cmd   = bus_wdata[CMD_B];
  wire [IDX_W-1:0] wr_idx = bus_wdata[IDX_W-1:0];
  wire unused_wdata = ^{bus_wdata[31:25], bus_wdata[23:21], bus_wdata[19:18], bus_wdata[15:IDX_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      en1_q <= '0;
      ptr_q <= '0;
    end else if (wr) begin
      ptr_q <= wr_idx;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cmd && wr_idx == IDX_W'(i)) begin
          en_q[i]  <= bus_wdata[EN_B];
          pol_q[i] <= bus_wdata[POL_B];
          en1_q[i] <= bus_wdata[EN1_B];
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[IDX_W-1:0] = ptr_q;
    rd_word[EN_B]  = en_q[ptr_q];
    rd_word[POL_B] = pol_q[ptr_q];
    rd_word[EN1_B] = en1_q[ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_word : '0;
    end
  end

  wire [NUM_SRC-1:0] active = ~(sync2 ^ pol_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1         <= '0;
      sync2         <= '0;
      restart_core0 <= 1'b0;
      restart_core1 <= 1'b0;
    end else begin
      sync1         <= wake_in;
      sync2         <= sync1;
      restart_core0 <= |(en_q & active);
      restart_core1 <= |(en1_q & active);
    end
  end

  assert_cmd0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !cmd) |=> ($stable(en_q) && $stable(pol_q) && $stable(en1_q)));

  assert_other_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr != REG_OFFSET) |=>
      ($stable(en_q) && $stable(pol_q) && $stable(en1_q) && $stable(ptr_q) && !bus_rvalid));

  assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);

  assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~USED_MASK) == 32'd0);

  assert_core0_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_core0 |-> $past(|en_q));

  assert_core1_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_core1 |-> $past(|en1_q));
endmodule

// File: tb/tb_wakeup_cfg_reg.sv
module tb_wakeup_cfg_reg;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [15:0] wake_in = '0;
  logic restart_core0, restart_core1;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [15:0] m_en = '0, m_pol = '0, m_en1 = '0;
  logic [3:0] m_ptr = '0;

  always #5 clk = ~clk;

  wakeup_cfg_reg dut (.clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
                      .bus_rdata, .bus_rvalid, .wake_in, .restart_core0, .restart_core1);

  function automatic logic [31:0] word(logic [3:0] idx);
    logic [31:0] w = '0;
    w[3:0] = idx; w[16] = m_en[idx]; w[17] = m_pol[idx]; w[20] = m_en1[idx];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, bit cmd, bit en, bit pol, bit en1,
                    logic [31:0] junk = '0, logic [7:0] addr = 8'h78);
    logic [31:0] d = junk;
    d[3:0] = idx; d[24] = cmd; d[16] = en; d[17] = pol; d[20] = en1;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = addr; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    if (addr == 8'h78) begin
      m_ptr = idx;
      if (cmd) begin m_en[idx] = en; m_pol[idx] = pol; m_en1[idx] = en1; end
    end
  endtask

  task automatic rd(string req, logic [7:0] addr = 8'h78);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = addr;
    if (addr == 8'h78) begin exp_q.push_back(word(m_ptr)); tag_q.push_back(req); end
    @(negedge clk);
    bus_valid = 0;
    @(negedge clk);
  endtask

  function automatic bit exp_r0();
    return |(m_en & ~(wake_in ^ m_pol));
  endfunction
  function automatic bit exp_r1();
    return |(m_en1 & ~(wake_in ^ m_pol));
  endfunction

  task automatic settle(string req);
    repeat (4) @(negedge clk);
    check({req, " core0"}, 32'(restart_core0), 32'(exp_r0()));
    check({req, " core1"}, 32'(restart_core1), 32'(exp_r1()));
  endtask

  // Monitor: pops scoreboard entries as read data appears
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected rvalid actual=%h expected=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 core0", 32'(restart_core0), 0);
    check("R1 core1", 32'(restart_core1), 0);
    rd("R1");
    // R2 store, R7 latency, R9 active-high
    wr(4'd3, 1, 1, 1, 0);
    rd("R2");
    settle("R7 idle");
    @(negedge clk); wake_in[3] = 1;
    repeat (2) @(negedge clk);
    check("R7 before third edge", 32'(restart_core0), 0);
    @(negedge clk);
    check("R7 after third edge", 32'(restart_core0), 1);
    // R8 core1 independent, R9 active-low
    wr(4'd5, 1, 0, 0, 1);
    settle("R8 R9 low active");
    wake_in[5] = 1;
    settle("R9 inactive high");
    wake_in[3] = 0;
    settle("R7 drop");
    // R3 pointer-only write
    wr(4'd3, 0, 0, 0, 1, 32'hFFFF_FFFF);
    rd("R3");
    settle("R3 restart unchanged");
    // R6 other offset ignored
    wr(4'd7, 1, 1, 1, 1, 32'h0, 8'h7C);
    rd("R6 pointer kept");
    rd("R6 no rvalid", 8'h74);
    wr(4'd7, 0, 0, 0, 0);
    rd("R6 entry untouched");
    // R5 unused bits zero
    wr(4'd15, 1, 1, 0, 1, 32'hFFFF_FFFF);
    rd("R5");
    // R10 all entries independent
    for (int i = 0; i < 16; i++) wr(4'(i), 1, i[0], i[1], i[2]);
    for (int i = 0; i < 16; i++) begin
      wr(4'(i), 0, 0, 0, 0);
      rd("R10");
    end
    wake_in = 16'hA5C3;
    settle("R7 R8 pattern");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule